// File: doc/BRIEF.md
# Parallel Tree Reduction Engine

This block adds up a set of N partial results of W bits each. A single accepted launch captures all N values at once into a register array. The array then collapses in a tree of pairwise additions, one tree level per clock cycle. In each level the slots below the current stride each take in the value that sits one stride above them. The stride starts at half the element count and halves after every level, so the live slots always form a contiguous group at the low end of the array. After log2(N) levels the grand total sits in slot 0. It is copied to the sum output, and a one-cycle done pulse marks its arrival.

The controller has two states. RS_IDLE waits for a launch. RS_REDUCE runs one tree level per cycle. The transition RS_IDLE to RS_REDUCE (launch) happens when start and valid are both high in an idle cycle; it loads the array and sets the stride to N/2. The transition RS_REDUCE to RS_REDUCE (descend) halves the stride after a level whose stride is greater than 1. The transition RS_REDUCE to RS_IDLE (finish) follows the level whose stride is 1; it captures the total and raises done. A launch presented in the same cycle as the done pulse is accepted, so passes can run back to back.

Top module: `tree_sum_engine`

## Requirements
- R1: After reset, busy_o, done_o and sum_o are all 0.
- R2: A launch is accepted only when start_i and valid_i are both high in a cycle where busy_o is low. A start_i with valid_i low leaves busy_o, done_o and sum_o unchanged.
- R3: busy_o rises in the cycle after an accepted launch and stays high for exactly log2(N) cycles.
- R4: done_o is high for exactly one cycle. That cycle comes log2(N) cycles after the launch edge, and busy_o falls in the same cycle.
- R5: When done_o is high, sum_o equals the sum of all N input values modulo 2^W. Input element i occupies bits [i*W +: W] of vals_i.
- R6: A start_i raised while busy_o is high is ignored: the running pass keeps its timing and its result.
- R7: sum_o becomes 0 in the cycle after an accepted launch. It changes again only when done_o rises, and then holds until the next accepted launch.
- R8: Each level adds the element one stride above into every slot below the stride, starting with stride N/2. Slots at or above N/2 never change during a pass. A value placed in any single position, including the highest, reaches the total.
- R9: A launch presented in the cycle where done_o is high is accepted, and it starts a new pass with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request |
| valid_i | input | 1 | Qualifies vals_i for a launch |
| vals_i | input | N*W | N packed input values, element i at [i*W +: W] |
| sum_o | output | W | Total of the last finished pass |
| done_o | output | 1 | One-cycle pulse when the total is ready |
| busy_o | output | 1 | A reduction is in progress |

## Verification
The reduction is driven with all-zero and all-ones buffers, which test carry wrap modulo 2^W. It is also driven with buffers that have one nonzero value at position 0 or at position N-1; these show whether every tree path carries its operand down to slot 0. An ascending ramp and seeded random buffers check the arithmetic in general. Launches without valid, launches during a pass and launches on the done cycle test the acceptance rule separately from the adder tree.

// File: rtl/tree_sum_pkg.sv
package tree_sum_pkg;
    typedef enum logic [0:0] {
        RS_IDLE   = 1'b0,
        RS_REDUCE = 1'b1
    } red_state_e;
endpackage

// File: rtl/tree_sum_ctrl.sv
module tree_sum_ctrl
    import tree_sum_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 valid_i,
    output logic                 load_o,
    output logic                 step_o,
    output logic                 last_o,
    output logic [$clog2(N)-1:0] stride_o,
    output logic                 busy_o,
    output logic                 done_o
);
    localparam int IW   = $clog2(N);
    localparam int HALF = N / 2;

    red_state_e      state_q, state_nx;
    logic [IW-1:0]   stride_q, stride_nx;
    logic            done_q;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RS_IDLE;
            stride_q <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_nx;
            stride_q <= stride_nx;
            done_q   <= last_o;
        end
    end

    // next-state logic: launch, descend, finish
    always_comb begin
        state_nx  = state_q;
        stride_nx = stride_q;
        unique case (state_q)
            RS_IDLE: begin
                if (start_i && valid_i) begin
                    state_nx  = RS_REDUCE;
                    stride_nx = IW'(HALF);
                end
            end
            RS_REDUCE: begin
                if (stride_q == IW'(1)) begin
                    state_nx  = RS_IDLE;
                    stride_nx = '0;
                end else begin
                    stride_nx = stride_q >> 1;
                end
            end
            default: begin
                state_nx  = RS_IDLE;
                stride_nx = '0;
            end
        endcase
    end

    // output process
    always_comb begin
        busy_o   = (state_q == RS_REDUCE);
        load_o   = (state_q == RS_IDLE) && start_i && valid_i;
        step_o   = busy_o;
        last_o   = busy_o && (stride_q == IW'(1));
        stride_o = stride_q;
        done_o   = done_q;
    end

    // R3
    stride_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (stride_q != '0) && $onehot0(stride_q));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !last_o) |=> busy_o);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_o);
endmodule

// File: rtl/tree_sum_lanes.sv
module tree_sum_lanes #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 step_i,
    input  logic [$clog2(N)-1:0] stride_i,
    input  logic [N*W-1:0]       vals_i,
    output logic [W-1:0]         head_nx_o
);
    localparam int IW   = $clog2(N);
    localparam int HALF = N / 2;

    logic [W-1:0] elem [N];
    logic [W-1:0] nx   [N];

    for (genvar t = 0; t < N; t++) begin : g_lane
        if (t < HALF) begin : g_add
            logic [IW-1:0] pidx;
            logic          live;
            assign pidx  = IW'(t) + stride_i;
            assign live  = step_i && (IW'(t) < stride_i);
            assign nx[t] = load_i ? vals_i[t*W +: W]
                         : live   ? elem[t] + elem[pidx]
                         :          elem[t];
        end else begin : g_hold
            assign nx[t] = load_i ? vals_i[t*W +: W] : elem[t];

            // R8
            upper_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
                step_i |=> $stable(elem[t]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) elem[k] <= '0;
        end else begin
            for (int k = 0; k < N; k++) elem[k] <= nx[k];
        end
    end

    assign head_nx_o = nx[0];
endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           valid_i,
    input  logic [N*W-1:0] vals_i,
    output logic [W-1:0]   sum_o,
    output logic           done_o,
    output logic           busy_o
);
    localparam int IW    = $clog2(N);
    localparam int STEPS = $clog2(N);

    logic          load, step, last;
    logic [IW-1:0] stride;
    logic [W-1:0]  head_nx;
    logic [W-1:0]  sum_q;

    tree_sum_ctrl #(.N(N)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .valid_i  (valid_i),
        .load_o   (load),
        .step_o   (step),
        .last_o   (last),
        .stride_o (stride),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    tree_sum_lanes #(.N(N), .W(W)) lanes_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .stride_i  (stride),
        .vals_i    (vals_i),
        .head_nx_o (head_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sum_q <= '0;
        else if (load) sum_q <= '0;
        else if (last) sum_q <= head_nx;
    end

    assign sum_o = sum_q;

    // cycle counter used only by the latency check
    logic [IW:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_cnt <= '0;
        else if (load)   lat_cnt <= '0;
        else if (busy_o) lat_cnt <= lat_cnt + 1'b1;
    end

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_cnt == (IW+1)'(STEPS)));

    // R4
    done_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7
    sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !last) |=> $stable(sum_o));

    // R7
    sum_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sum_o == '0));
endmodule

// File: tb/tree_sum_engine_tb_top.sv
module tree_sum_engine_tb_top;
    localparam int N = 16;
    localparam int W = 16;
    localparam int L = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           valid_i = 1'b0;
    logic [N*W-1:0] vals_i = '0;
    logic [W-1:0]   sum_o;
    logic           done_o;
    logic           busy_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tree_sum_engine #(.N(N), .W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (valid_i),
        .vals_i  (vals_i),
        .sum_o   (sum_o),
        .done_o  (done_o),
        .busy_o  (busy_o)
    );

    function automatic logic [W-1:0] ref_sum(input logic [N*W-1:0] v);
        logic [W-1:0] acc = '0;
        for (int i = 0; i < N; i++) acc = acc + v[i*W +: W];
        return acc;
    endfunction

    function automatic logic [N*W-1:0] rand_vec();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called right after start_i/valid_i/vals_i were driven at a negedge
    task automatic follow(input logic [N*W-1:0] v, input int inj,
                          input bit chain, input logic [N*W-1:0] v2);
        logic [W-1:0] exp = ref_sum(v);
        @(negedge clk);
        start_i = 1'b0; valid_i = 1'b0;
        chk(busy_o == 1'b1, "R3 busy after launch", busy_o, 1);
        chk(done_o == 1'b0, "R4 no early done", done_o, 0);
        chk(sum_o == '0, "R7 sum cleared", sum_o, 0);
        for (int i = 1; i <= L; i++) begin
            if (i == inj) begin
                start_i = 1'b1; valid_i = 1'b1; vals_i = ~v;
            end
            @(negedge clk);
            start_i = 1'b0; valid_i = 1'b0;
            if (i < L) begin
                chk(busy_o && !done_o, "R3 busy during pass", {busy_o, done_o}, 2);
            end else begin
                chk(!busy_o && done_o, "R4 done at step count", {busy_o, done_o}, 1);
                chk(sum_o == exp, "R5 total", sum_o, exp);
            end
        end
        if (chain) begin
            vals_i = v2; start_i = 1'b1; valid_i = 1'b1;
        end else begin
            @(negedge clk);
            chk(!done_o && !busy_o, "R4 done single pulse", {busy_o, done_o}, 0);
            chk(sum_o == exp, "R7 sum holds", sum_o, exp);
        end
    endtask

    task automatic go(input logic [N*W-1:0] v, input int inj);
        vals_i = v; start_i = 1'b1; valid_i = 1'b1;
        follow(v, inj, 1'b0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] v;
        logic [W-1:0]   prev;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy_o && !done_o && sum_o == '0, "R1 reset state", {busy_o, done_o, sum_o}, 0);

        // R5 directed patterns
        go('0, 0);
        go('1, 0);
        v = '0;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(i + 1);
        go(v, 0);

        // R8 single nonzero at highest and lowest position
        v = '0; v[(N-1)*W +: W] = W'(16'h1234);
        go(v, 0);
        v = '0; v[0 +: W] = W'(16'h0ABC);
        go(v, 0);
        chk(sum_o == W'(16'h0ABC), "R8 lone slot 0 reaches total", sum_o, 16'h0ABC);

        // R2 start without valid ignored
        prev = sum_o;
        vals_i = rand_vec(); start_i = 1'b1; valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(!busy_o, "R2 no launch without valid", busy_o, 0);
        for (int i = 0; i < L + 1; i++) begin
            @(negedge clk);
            chk(!done_o && sum_o == prev, "R2 outputs untouched", {done_o, sum_o}, prev);
        end

        // R6 start during a pass ignored, at several levels
        for (int j = 1; j <= L; j++) go(rand_vec(), j);

        // R9 back-to-back on the done cycle
        begin
            logic [N*W-1:0] a, b;
            a = rand_vec(); b = rand_vec();
            vals_i = a; start_i = 1'b1; valid_i = 1'b1;
            follow(a, 0, 1'b1, b);
            // R9 second pass accepted with the same timing
            follow(b, 0, 1'b0, '0);
        end

        // R5 seeded random passes
        for (int k = 0; k < 24; k++) go(rand_vec(), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule